// File: doc/BRIEF.md
# Table-Based Chunked Constant Multiplier

This block multiplies an input word by a constant fixed at elaboration time. It uses no multiplier. The input is cut into slices of `ALPHA` bits. Each slice is the address of a small table that holds the constant times every value the slice can take. The table outputs are weighted by powers of 2^ALPHA and added to give the exact product. Area grows in proportion to the input width, one table per slice, instead of growing exponentially as a single table over the whole input would.

The table contents are worked out during elaboration from `MULT_K` and `ALPHA`. When the input width is not a multiple of `ALPHA`, the top slice is padded. The pad is sign bits for a two's complement input and zero bits for an unsigned one. For a signed input, only the top slice is read as two's complement, so its table holds signed products. Every lower slice is unsigned.

A register stage sits after the tables, and a second one sits after a balanced adder tree. The result therefore appears two cycles after its input is accepted. The block accepts one new input per cycle. Reset is asserted asynchronously, active low, and is released through an internal two-flop synchronizer.

Top module: `kcm_mult`

## Requirements
- R1: When `out_valid` is high, `out_data` equals the exact product of the accepted input and `MULT_K`, as an `IN_W+CONST_W` bit word. That word is two's complement when `SIGNED_IN` is 1 and unsigned when it is 0.
- R2: An input presented with `in_valid` high at a rising edge produces `out_valid` high exactly two rising edges later. Back-to-back inputs give back-to-back results, and `out_valid` is low in every other cycle.
- R3: Every single input bit position, including the first and last bit of each `ALPHA`-bit slice, contributes `MULT_K` times that bit's weight.
- R4: With a signed input, the most negative value -2^(IN_W-1) yields -2^(IN_W-1) times `MULT_K`. More generally, the top slice's table entry is negative whenever the input's sign bit is set and `MULT_K` is non-zero.
- R5: The all-ones input yields -`MULT_K` in signed mode and (2^IN_W - 1) times `MULT_K` in unsigned mode.
- R6: When `IN_W` is at most `ALPHA`, the product comes from one zero-padded table read with the same two-cycle latency. Every input value gives its exact product.
- R7: While `rst_n` is low, `out_valid` and `out_data` are 0. This also holds when reset is asserted in the middle of operation.
- R8: When no input was accepted two edges earlier, `out_data` keeps its previous value, whatever `in_data` carries.
- R9: A zero input yields a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside the block |
| in_valid | input | 1 | `in_data` carries an operand this cycle |
| in_data | input | IN_W | Operand, two's complement if `SIGNED_IN` is 1, else unsigned |
| out_valid | output | 1 | `out_data` holds a new product |
| out_data | output | IN_W+CONST_W | Exact product of the operand and `MULT_K` |

## Verification
The bench builds the block twice. The first build is the default: an 18-bit signed input, an 18-bit constant of 205887 and `ALPHA` of 6. It has three slices and a signed top slice, so the adder tree, the alignment of each slice and the most negative and all-ones values can all be tested. The second build uses a 5-bit unsigned input, a 7-bit constant of 93 and `ALPHA` of 6. This selects the single-table variant with a zero-padded slice, and its whole input space is swept. The streaming steps compare `out_valid` in every cycle, so latency, hold and the effect of bubbles are checked together with the products.

// File: rtl/kcm_pkg.sv
package kcm_pkg;

  // Number of ALPHA-bit slices needed to cover an in_w-bit word
  function automatic int slice_count(input int in_w, input int alpha);
    return (in_w + alpha - 1) / alpha;
  endfunction

  // Depth of a balanced binary tree with n leaves
  function automatic int tree_depth(input int n);
    int depth;
    int span;
    depth = 0;
    span  = 1;
    while (span < n) begin
      span  = span * 2;
      depth = depth + 1;
    end
    return depth;
  endfunction

endpackage

// File: rtl/kcm_rst_sync.sv
module kcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/kcm_slice_table.sv
module kcm_slice_table #(
  parameter int                  ALPHA      = 6,
  parameter int                  CONST_W    = 18,
  parameter logic [CONST_W-1:0]  MULT_K     = '0,
  parameter bit                  TOP_SIGNED = 1'b0,
  localparam int                 TW         = ALPHA + CONST_W + 1
) (
  input  logic [ALPHA-1:0]     addr,
  output logic signed [TW-1:0] prod
);

  localparam int DEPTH = 1 << ALPHA;

  logic signed [TW-1:0] rom [DEPTH];

  // Each entry is MULT_K times the slice value; the slice value is read
  // as two's complement only in the table that serves the top slice.
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    localparam longint SLICE_VAL =
      (TOP_SIGNED && (e >= DEPTH / 2)) ? longint'(e) - longint'(DEPTH) : longint'(e);
    assign rom[e] = TW'(SLICE_VAL * longint'(MULT_K));
  end

  assign prod = rom[addr];

endmodule

// File: rtl/kcm_adder_tree.sv
module kcm_adder_tree #(
  parameter int N = 3,
  parameter int W = 36
) (
  input  logic signed [W-1:0] leaf [N],
  output logic signed [W-1:0] total
);

  localparam int DEPTH = kcm_pkg::tree_depth(N);
  localparam int NP    = 1 << DEPTH;
  localparam int NN    = 2 * NP - 1;

  // Heap layout: node 0 is the root, leaves occupy NP-1 .. 2*NP-2
  logic signed [W-1:0] node [NN];

  for (genvar k = 0; k < NP; k++) begin : g_leaf
    if (k < N) begin : g_used
      assign node[NP-1+k] = leaf[k];
    end else begin : g_pad
      assign node[NP-1+k] = '0;
    end
  end

  for (genvar k = 0; k < NP - 1; k++) begin : g_sum
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign total = node[0];

endmodule

// File: rtl/kcm_mult.sv
module kcm_mult #(
  parameter int                 IN_W      = 18,
  parameter int                 CONST_W   = 18,
  parameter logic [CONST_W-1:0] MULT_K    = 18'd205887,
  parameter int                 ALPHA     = 6,
  parameter bit                 SIGNED_IN = 1'b1,
  localparam int                PW        = IN_W + CONST_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  output logic            out_valid,
  output logic [PW-1:0]   out_data
);

  localparam int NCH   = kcm_pkg::slice_count(IN_W, ALPHA);
  localparam int PAD_W = NCH * ALPHA;
  localparam int TW    = ALPHA + CONST_W + 1;

  logic rst_n_s;

  kcm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Pad the operand to a whole number of slices
  logic [PAD_W-1:0] in_pad;

  if (SIGNED_IN) begin : g_pad_sign
    assign in_pad = PAD_W'($signed(in_data));
  end else begin : g_pad_zero
    assign in_pad = PAD_W'(in_data);
  end

  // Slice tables
  logic signed [TW-1:0] tab_out [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_slice
    kcm_slice_table #(
      .ALPHA      (ALPHA),
      .CONST_W    (CONST_W),
      .MULT_K     (MULT_K),
      .TOP_SIGNED (SIGNED_IN && (c == NCH - 1))
    ) u_tab (
      .addr (in_pad[c*ALPHA +: ALPHA]),
      .prod (tab_out[c])
    );
  end

  // Stage 1: table outputs
  logic                 s1_valid_d, s1_valid_q;
  logic signed [TW-1:0] s1_part_d [NCH];
  logic signed [TW-1:0] s1_part_q [NCH];

  always_comb begin
    s1_valid_d = in_valid;
    for (int c = 0; c < NCH; c++) begin
      s1_part_d[c] = in_valid ? tab_out[c] : s1_part_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      s1_valid_q <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        s1_part_q[c] <= '0;
      end
    end else begin
      s1_valid_q <= s1_valid_d;
      for (int c = 0; c < NCH; c++) begin
        s1_part_q[c] <= s1_part_d[c];
      end
    end
  end

  // Alignment: slice c carries weight 2^(ALPHA*c)
  logic signed [PW-1:0] aligned [NCH];
  logic signed [PW-1:0] sum_total;

  for (genvar c = 0; c < NCH; c++) begin : g_align
    assign aligned[c] = PW'(s1_part_q[c]) <<< (ALPHA * c);
  end

  if (NCH == 1) begin : g_single
    assign sum_total = aligned[0];
  end else begin : g_tree
    kcm_adder_tree #(
      .N (NCH),
      .W (PW)
    ) u_tree (
      .leaf  (aligned),
      .total (sum_total)
    );
  end

  // Stage 2: final sum
  logic          out_valid_d, out_valid_q;
  logic [PW-1:0] out_data_d,  out_data_q;

  always_comb begin
    out_valid_d = s1_valid_q;
    out_data_d  = s1_valid_q ? sum_total : out_data_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      out_data_q  <= out_data_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  // Independent reference for the end-to-end check
  logic signed [PW-1:0] chk_in, chk_k, chk_prod;

  if (SIGNED_IN) begin : g_chk_sign
    assign chk_in = PW'($signed(in_data));
  end else begin : g_chk_zero
    assign chk_in = PW'(in_data);
  end
  assign chk_k    = PW'(MULT_K);
  assign chk_prod = chk_in * chk_k;

  AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |-> (out_data == $past(chk_prod, 2))); // R1

  AST_OUT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |-> $past(in_valid, 2)); // R2

  AST_STAGE_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_valid |=> s1_valid_q); // R2

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n_s)
    !s1_valid_q |=> $stable(out_data)); // R8

  AST_ZERO_SLICE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && (in_pad[ALPHA-1:0] == '0)) |=> (s1_part_q[0] == '0)); // R9

  if (SIGNED_IN) begin : g_sign_chk
    AST_NEG_TOP: assert property (@(posedge clk) disable iff (!rst_n_s)
      (in_valid && in_data[IN_W-1] && (MULT_K != '0)) |=> (s1_part_q[NCH-1] < 0)); // R4
  end

endmodule

// File: tb/sim_kcm_mult.sv
module sim_kcm_mult;

  localparam int  W0 = 18;
  localparam int  P0 = 36;
  localparam int  W1 = 5;
  localparam int  P1 = 12;
  localparam int  NV = 16;

  // Stimulus table: the expected product of each entry is in_data * 205887
  localparam logic [W0-1:0] VEC [NV] = '{
    18'h00000, 18'h3FFFF, 18'h20000, 18'h1FFFF,
    18'h00001, 18'h0003F, 18'h00040, 18'h00FC0,
    18'h01000, 18'h3F000, 18'h2AAAA, 18'h15555,
    18'h12345, 18'h3EDCB, 18'h0FFFF, 18'h30000
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid0, in_valid1;
  logic [W0-1:0] in_data0;
  logic [W1-1:0] in_data1;
  logic out_valid0, out_valid1;
  logic [P0-1:0] out_data0;
  logic [P1-1:0] out_data1;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  kcm_mult u0 (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid0), .in_data (in_data0),
    .out_valid (out_valid0), .out_data (out_data0)
  );

  kcm_mult #(
    .IN_W (5), .CONST_W (7), .MULT_K (7'd93), .ALPHA (6), .SIGNED_IN (1'b0)
  ) u1 (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid1), .in_data (in_data1),
    .out_valid (out_valid1), .out_data (out_data1)
  );

  function automatic longint ref0(input logic [W0-1:0] x);
    return longint'($signed(x)) * 64'sd205887;
  endfunction

  function automatic longint ref1(input logic [W1-1:0] x);
    return longint'(x) * 64'sd93;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Two-deep history of what each instance was given
  bit            h0_v [2];
  logic [W0-1:0] h0_d [2];
  string         h0_t [2];
  longint        last0;
  bit            h1_v [2];
  logic [W1-1:0] h1_d [2];
  longint        last1;

  task automatic clear_hist();
    for (int k = 0; k < 2; k++) begin
      h0_v[k] = 1'b0; h0_d[k] = '0; h0_t[k] = "R1";
      h1_v[k] = 1'b0; h1_d[k] = '0;
    end
    last0 = 0;
    last1 = 0;
  endtask

  task automatic step0(input bit v, input logic [W0-1:0] d, input string tag);
    @(negedge clk);
    check("R2 u0 valid", longint'(out_valid0), longint'(h0_v[1]));
    if (h0_v[1]) begin
      last0 = ref0(h0_d[1]);
      check(h0_t[1], longint'($signed(out_data0)), last0);
    end else begin
      check("R8 u0 hold", longint'($signed(out_data0)), last0);
    end
    h0_v[1] = h0_v[0]; h0_d[1] = h0_d[0]; h0_t[1] = h0_t[0];
    h0_v[0] = v;       h0_d[0] = d;       h0_t[0] = tag;
    in_valid0 = v;
    in_data0  = d;
  endtask

  task automatic step1(input bit v, input logic [W1-1:0] d);
    @(negedge clk);
    check("R2 u1 valid", longint'(out_valid1), longint'(h1_v[1]));
    if (h1_v[1]) begin
      last1 = ref1(h1_d[1]);
      check("R6 u1 product", longint'(out_data1), last1);
    end else begin
      check("R8 u1 hold", longint'(out_data1), last1);
    end
    h1_v[1] = h1_v[0]; h1_d[1] = h1_d[0];
    h1_v[0] = v;       h1_d[0] = d;
    in_valid1 = v;
    in_data1  = d;
  endtask

  task automatic check_reset_state();
    check("R7 u0 valid", longint'(out_valid0), 0);
    check("R7 u0 data",  longint'(out_data0), 0);
    check("R7 u1 valid", longint'(out_valid1), 0);
    check("R7 u1 data",  longint'(out_data1), 0);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    clear_hist();
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid0 = 1'b0; in_data0 = '0;
    in_valid1 = 1'b0; in_data1 = '0;
    clear_hist();
    repeat (3) @(negedge clk);
    check_reset_state();
    release_reset();

    // Table walk, streamed back to back
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = "R1 product";
      if (i == 0) tag = "R9 zero";
      if (i == 1) tag = "R5 all ones";
      if (i == 2) tag = "R4 most negative";
      step0(1'b1, VEC[i], tag);
    end
    step0(1'b0, 18'h0AAAA, "R1");
    step0(1'b0, 18'h15555, "R1");

    // Single bit in every position, covering every slice edge
    for (int b = 0; b < W0; b++) begin
      step0(1'b1, W0'(1) << b, "R3 walking one");
    end

    // Isolated pulse and bubbles: data changes while invalid must not leak
    step0(1'b0, 18'h3FFFF, "R1");
    step0(1'b0, 18'h3FFFF, "R1");
    step0(1'b1, 18'h2F00D, "R2 pulse");
    step0(1'b0, 18'h12345, "R1");
    step0(1'b0, 18'h00000, "R1");
    step0(1'b0, 18'h3C0C0, "R1");
    step0(1'b1, 18'h00FFF, "R1 after gap");
    step0(1'b1, 18'h3F03F, "R1 back to back");
    step0(1'b0, 18'h11111, "R1");
    step0(1'b0, 18'h22222, "R1");
    step0(1'b0, 18'h33333, "R1");

    // Single-table build: every input value
    for (int x = 0; x < (1 << W1); x++) begin
      step1(1'b1, W1'(x));
    end
    step1(1'b0, 5'h1F);
    step1(1'b0, 5'h0A);
    step1(1'b0, 5'h15);
    check("R5 u1 all ones", longint'(out_data1), 31 * 93);

    // Reset in the middle of a stream
    step0(1'b1, 18'h1ABCD, "R1");
    step0(1'b1, 18'h2BCDE, "R1");
    step0(1'b1, 18'h3CDEF, "R1");
    #2;
    rst_n = 1'b0;
    #1;
    check_reset_state();
    @(negedge clk);
    in_valid0 = 1'b0;
    check_reset_state();
    release_reset();
    step0(1'b1, 18'h00007, "R1 after reset");
    step0(1'b0, 18'h0, "R1");
    step0(1'b0, 18'h0, "R1");
    step0(1'b0, 18'h0, "R1");

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule